// File: doc/BRIEF.md
# Asynchronous SRAM Module Controller

This block sits between a clocked host and an asynchronous static RAM module that has nineteen address lines, a 32-bit data bus, four active-low chip selects, a write strobe and an output strobe. The host hands it one request at a time over a valid/ready handshake. Each request carries an address, write data, a write flag and a width flag. The controller turns the request into a pin-level read or write cycle. Every phase length is a whole number of clock cycles, derived from nanosecond parameters.

The module is built as two banks. Each bank has a low half (data lines 0 to 15) and a high half (data lines 16 to 31), and each half has its own chip select. In word mode a request enables both halves of one bank. In halfword mode it enables one half only. Write data is copied onto both halves of the bus, and read data is taken from the addressed half. The data bus is split into an output word, a drive enable and an input word. After a read, the drivers stay off until the module's outputs have had time to float.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, all four chip selects, the write strobe and the output strobe are high. The data drive enable is low, rsp_valid is low and req_ready is high.
- R2: In word mode (req_mode16=0), host address bit 19 selects the bank: 0 drives mem_cs_n=4'b1100 and 1 drives mem_cs_n=4'b0011. Host bits 18:0 appear on mem_addr.
- R3: In halfword mode (req_mode16=1), exactly one chip select is low: mem_cs_n bit index {addr[20],addr[0]}. Host bits 19:1 appear on mem_addr. Bit 0 of mem_cs_n drives data lines 15:0 of bank 0, bit 1 drives lines 31:16 of bank 0, and bits 2 and 3 do the same for bank 1.
- R4: An accepted write sets mem_we_n low, the chip selects, mem_addr, mem_dq_out and mem_dq_oe=1 from the next clock edge. These hold steady for WL = max(write-pulse cycles, data-setup cycles) cycles with mem_oe_n high. At the following edge the chip selects and the write strobe go high and the drivers turn off.
- R5: A halfword write places req_wdata[15:0] on both halves of mem_dq_out. A word write places req_wdata unchanged.
- R6: An accepted read sets mem_oe_n low with mem_we_n high and the drivers off for A access cycles. At the end of the last cycle it samples mem_dq_in, raises the strobes and presents the data with a one-cycle rsp_valid pulse.
- R7: A halfword read returns the addressed half in rsp_rdata[15:0], with the upper 16 bits zero. A word read returns all 32 input bits.
- R8: A write that follows a read does not turn mem_dq_oe on until T float cycles after the edge that ended the read. Until then, req_ready stays low and the chip selects stay high.
- R9: req_ready is high only when no cycle is in progress. In that state all chip selects are high, so a request is accepted only on a cycle where req_valid and req_ready are both high.
- R10: The access, write-pulse, data-setup and float counts each equal the ceiling of their nanosecond parameter divided by CLK_NS, and are at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode16 | input | 1 | 1 = halfword mode, 0 = word mode |
| req_addr | input | 21 | Host address (word mode uses bits 19:0) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 19 | Module address lines |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 32 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 32 | Data sampled from the bus |

## Verification
All memory pins are registered, so a request accepted at edge k changes the pins at edge k and the bench sees the change at the next falling edge. The write pins then hold for WL falling edges. The read pins hold for A falling edges, and rsp_valid with its data appears at the falling edge after edge k+A. The bench counts edges from reset to find the accepting edge of each request and the edge that ended the last read. From those it works out how many idle turnaround edges must come before a write starts. It samples every pin on each falling edge of that predicted window, using a behavioural halfword store as the expected data.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_WR,
    ST_RD
  } seq_t;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/asram_decode.sv
module asram_decode #(
  parameter int unsigned MA_W = 19,
  parameter int unsigned HA_W = MA_W + 2,
  parameter int unsigned NCS  = 4
) (
  input  logic [HA_W-1:0] host_addr,
  input  logic            mode16,
  output logic [MA_W-1:0] pin_addr,
  output logic [NCS-1:0]  sel,
  output logic            half_hi
);
  logic bank;

  always_comb begin
    if (mode16) begin
      pin_addr = host_addr[MA_W:1];
      bank     = host_addr[MA_W+1];
      half_hi  = host_addr[0];
    end else begin
      pin_addr = host_addr[MA_W-1:0];
      bank     = host_addr[MA_W];
      half_hi  = 1'b0;
    end
  end

  // select g belongs to bank g/2 and data half g%2
  for (genvar g = 0; g < NCS; g++) begin : g_sel
    localparam logic [1:0] IDX = 2'(g);
    assign sel[g] = (bank == IDX[1]) && (!mode16 || (half_hi == IDX[0]));
  end
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] wr_word,
  input  logic              wr_m16,
  output logic [DATA_W-1:0] wr_bus,
  input  logic [DATA_W-1:0] rd_bus,
  input  logic              rd_m16,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_word
);
  localparam int unsigned HW = DATA_W / 2;

  always_comb begin
    wr_bus = wr_m16 ? {2{wr_word[HW-1:0]}} : wr_word;
    if (!rd_m16)    rd_word = rd_bus;
    else if (rd_hi) rd_word = {{HW{1'b0}}, rd_bus[DATA_W-1:HW]};
    else            rd_word = {{HW{1'b0}}, rd_bus[HW-1:0]};
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int unsigned CLK_NS     = 20,
  parameter int unsigned T_ACC_NS   = 15,
  parameter int unsigned T_WP_NS    = 12,
  parameter int unsigned T_DS_NS    = 8,
  parameter int unsigned T_FLOAT_NS = 7,
  parameter int unsigned MA_W       = 19,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_mode16,
  input  logic [MA_W+1:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_valid,
  output logic [MA_W-1:0]   mem_addr,
  output logic [3:0]        mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  import asram_pkg::*;

  localparam int unsigned HA_W     = MA_W + 2;
  localparam int unsigned NCS      = 4;
  localparam int unsigned ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned DS_CYC   = ns_to_cyc(T_DS_NS, CLK_NS);
  localparam int unsigned TURN_CYC = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int unsigned WL_CYC   = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;
  localparam int unsigned MAX_A    = (ACC_CYC > WL_CYC) ? ACC_CYC : WL_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WL_LD   = CNT_W'(WL_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  seq_t              state;
  logic [CNT_W-1:0]  phase_cnt;
  logic [CNT_W-1:0]  float_cnt;
  logic [MA_W-1:0]   p_addr;
  logic [NCS-1:0]    p_sel;
  logic [DATA_W-1:0] p_data;
  logic              p_m16;
  logic              p_hi;

  logic [MA_W-1:0]   dec_addr;
  logic [NCS-1:0]    dec_sel;
  logic              dec_hi;
  logic [DATA_W-1:0] drv_data;
  logic [DATA_W-1:0] rd_word;

  asram_decode #(.MA_W(MA_W), .HA_W(HA_W), .NCS(NCS)) u_decode (
    .host_addr (req_addr),
    .mode16    (req_mode16),
    .pin_addr  (dec_addr),
    .sel       (dec_sel),
    .half_hi   (dec_hi)
  );

  asram_lanes #(.DATA_W(DATA_W)) u_lanes (
    .wr_word (req_wdata),
    .wr_m16  (req_mode16),
    .wr_bus  (drv_data),
    .rd_bus  (mem_dq_in),
    .rd_m16  (p_m16),
    .rd_hi   (p_hi),
    .rd_word (rd_word)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase_cnt  <= '0;
      float_cnt  <= '0;
      p_addr     <= '0;
      p_sel      <= '0;
      p_data     <= '0;
      p_m16      <= 1'b0;
      p_hi       <= 1'b0;
      mem_addr   <= '0;
      mem_cs_n   <= '1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (float_cnt != '0) float_cnt <= float_cnt - 1'b1;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            p_addr <= dec_addr;
            p_sel  <= dec_sel;
            p_data <= drv_data;
            p_m16  <= req_mode16;
            p_hi   <= dec_hi;
            if (!req_we) begin
              state     <= ST_RD;
              phase_cnt <= ACC_LD;
              mem_addr  <= dec_addr;
              mem_cs_n  <= ~dec_sel;
              mem_oe_n  <= 1'b0;
            end else if (float_cnt != '0) begin
              state <= ST_TURN;
            end else begin
              state      <= ST_WR;
              phase_cnt  <= WL_LD;
              mem_addr   <= dec_addr;
              mem_cs_n   <= ~dec_sel;
              mem_we_n   <= 1'b0;
              mem_dq_out <= drv_data;
              mem_dq_oe  <= 1'b1;
            end
          end
        end
        ST_TURN: begin
          if (float_cnt == '0) begin
            state      <= ST_WR;
            phase_cnt  <= WL_LD;
            mem_addr   <= p_addr;
            mem_cs_n   <= ~p_sel;
            mem_we_n   <= 1'b0;
            mem_dq_out <= p_data;
            mem_dq_oe  <= 1'b1;
          end
        end
        ST_WR: begin
          if (phase_cnt == '0) begin
            state     <= ST_IDLE;
            mem_cs_n  <= '1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end else begin
            phase_cnt <= phase_cnt - 1'b1;
          end
        end
        ST_RD: begin
          if (phase_cnt == '0) begin
            state     <= ST_IDLE;
            mem_cs_n  <= '1;
            mem_oe_n  <= 1'b1;
            rsp_rdata <= rd_word;
            rsp_valid <= 1'b1;
            float_cnt <= TURN_LD;
          end else begin
            phase_cnt <= phase_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned MA_W     = 19,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [MA_W-1:0]   mem_addr,
  input logic [3:0]        mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  int unsigned since_oe;

  always_ff @(posedge clk) begin
    if (rst)                    since_oe <= TURN_CYC;
    else if (!mem_oe_n)         since_oe <= 0;
    else if (since_oe < TURN_CYC) since_oe <= since_oe + 1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

  assert_bank_pair_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(~mem_cs_n) == 2) |-> (mem_cs_n == 4'b1100 || mem_cs_n == 4'b0011));

  assert_select_count_R3: assert property (@(posedge clk) disable iff (rst)
    ($countones(~mem_cs_n) != 3) && ($countones(~mem_cs_n) != 4));

  assert_write_pins_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && mem_cs_n != 4'hF));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_dq_out)));

  assert_read_pins_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_float_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (since_oe >= TURN_CYC));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n == 4'hF));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .MA_W(MA_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  // R10: 45/20 -> 3, 35/20 -> 2, 8/20 -> 1, 30/20 -> 2 (ceilings)
  localparam int A_CYC  = 3;
  localparam int WL_CYC = 2;
  localparam int T_CYC  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic        req_mode16 = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_valid;
  logic [18:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [31:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_in = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_end = -100;
  logic done = 1'b0;

  logic [15:0] chips [int];
  logic [15:0] refm  [int];

  always #10 clk = ~clk;

  asram_ctrl #(
    .CLK_NS(20), .T_ACC_NS(45), .T_WP_NS(35), .T_DS_NS(8), .T_FLOAT_NS(30)
  ) u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_mode16(req_mode16), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // pin-level module model: four 16-bit chips, key = select index * 2^19 + address
  always @(negedge clk) begin
    logic [31:0] bus;
    bus = 32'hA5A5_A5A5;
    for (int h = 0; h < 2; h++) begin
      for (int b = 0; b < 2; b++) begin
        int idx;
        int key;
        idx = b * 2 + h;
        key = idx * 524288 + int'(mem_addr);
        if (!mem_cs_n[idx]) begin
          if (!mem_we_n && mem_dq_oe)
            chips[key] = mem_dq_out[h*16 +: 16];
          else if (!mem_oe_n)
            bus[h*16 +: 16] = chips.exists(key) ? chips[key] : 16'h0000;
        end
      end
    end
    mem_dq_in <= bus;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(input logic m16, input logic [20:0] a);
    if (m16) return ~(4'b0001 << {a[20], a[0]});
    return a[19] ? 4'b0011 : 4'b1100;
  endfunction

  function automatic logic [18:0] exp_addr(input logic m16, input logic [20:0] a);
    return m16 ? a[19:1] : a[18:0];
  endfunction

  function automatic logic [15:0] ref_get(input int k);
    return refm.exists(k) ? refm[k] : 16'h0000;
  endfunction

  task automatic send(input logic we, input logic m16, input logic [20:0] a, input logic [31:0] d);
    req_valid  = 1'b1;
    req_we     = we;
    req_mode16 = m16;
    req_addr   = a;
    req_wdata  = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic m16, input logic [20:0] a, input logic [31:0] d);
    int ka;
    int turn;
    logic [31:0] ed;
    ka   = cyc + 1;
    turn = T_CYC - (ka - rd_end);
    if (turn < 0) turn = 0;
    ed = m16 ? {d[15:0], d[15:0]} : d;
    send(1'b1, m16, a, d);
    for (int i = 0; i < turn; i++) begin
      check("R8 turnaround drive", {31'b0, mem_dq_oe}, 32'd0);
      check("R8 turnaround cs", {28'b0, mem_cs_n}, 32'hF);
      check("R8 R9 turnaround ready", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    for (int i = 0; i < WL_CYC; i++) begin
      check(m16 ? "R3 write cs" : "R2 write cs", {28'b0, mem_cs_n}, {28'b0, exp_cs(m16, a)});
      check(m16 ? "R3 write addr" : "R2 write addr", {13'b0, mem_addr}, {13'b0, exp_addr(m16, a)});
      check("R4 R10 we low", {31'b0, mem_we_n}, 32'd0);
      check("R4 oe high", {31'b0, mem_oe_n}, 32'd1);
      check("R4 R8 drive on", {31'b0, mem_dq_oe}, 32'd1);
      check("R5 write data", mem_dq_out, ed);
      check("R9 busy", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    check("R4 write end cs", {28'b0, mem_cs_n}, 32'hF);
    check("R4 write end we", {31'b0, mem_we_n}, 32'd1);
    check("R4 write end drive", {31'b0, mem_dq_oe}, 32'd0);
    check("R9 ready again", {31'b0, req_ready}, 32'd1);
    if (m16) refm[int'(a)] = d[15:0];
    else begin
      refm[int'({a[19:0], 1'b0})] = d[15:0];
      refm[int'({a[19:0], 1'b1})] = d[31:16];
    end
  endtask

  task automatic do_read(input logic m16, input logic [20:0] a);
    int ka;
    logic [31:0] ev;
    ka = cyc + 1;
    if (m16) ev = {16'h0000, ref_get(int'(a))};
    else     ev = {ref_get(int'({a[19:0], 1'b1})), ref_get(int'({a[19:0], 1'b0}))};
    send(1'b0, m16, a, 32'h0);
    for (int i = 0; i < A_CYC; i++) begin
      check(m16 ? "R3 read cs" : "R2 read cs", {28'b0, mem_cs_n}, {28'b0, exp_cs(m16, a)});
      check(m16 ? "R3 read addr" : "R2 read addr", {13'b0, mem_addr}, {13'b0, exp_addr(m16, a)});
      check("R6 R10 oe low", {31'b0, mem_oe_n}, 32'd0);
      check("R6 we high", {31'b0, mem_we_n}, 32'd1);
      check("R6 drive off", {31'b0, mem_dq_oe}, 32'd0);
      check("R6 no early valid", {31'b0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
    check("R6 valid pulse", {31'b0, rsp_valid}, 32'd1);
    check(m16 ? "R7 halfword data" : "R7 word data", rsp_rdata, ev);
    check("R6 read end strobes", {26'b0, mem_cs_n, mem_oe_n, mem_we_n}, 32'h3F);
    check("R9 ready after read", {31'b0, req_ready}, 32'd1);
    rd_end = ka + A_CYC;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cs", {28'b0, mem_cs_n}, 32'hF);
    check("R1 reset strobes", {30'b0, mem_we_n, mem_oe_n}, 32'd3);
    check("R1 reset drive", {31'b0, mem_dq_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset cs", {28'b0, mem_cs_n}, 32'hF);
    check("R1 after reset valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 after reset ready", {31'b0, req_ready}, 32'd1);

    do_write(1'b0, 21'h00005, 32'h1122_3344);
    do_write(1'b0, 21'h80007, 32'hCAFE_F00D);
    do_read (1'b0, 21'h00005);
    do_read (1'b0, 21'h80007);
    // write straight after read: one extra idle cycle expected (R8)
    do_write(1'b1, 21'h1FFFFF, 32'h0000_BEEF);
    do_read (1'b1, 21'h0000A);
    do_read (1'b1, 21'h0000B);
    do_write(1'b1, 21'h0000B, 32'hFFFF_7777);
    do_read (1'b0, 21'h00005);
    do_read (1'b1, 21'h1FFFFF);
    do_read (1'b0, 21'hFFFFF);
    // read, one idle cycle, then write: gap already covers the float time
    do_read (1'b0, 21'h80007);
    @(negedge clk);
    do_write(1'b0, 21'h12345, 32'h0BAD_CAFE);
    do_read (1'b0, 21'h12345);
    do_read (1'b1, 21'h0468B);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule